// File: doc/BRIEF.md
# Sequential Byte/Word Shifter with Condition Flags

This unit shifts a byte or a 16-bit word left, or logically right, one bit position per clock. It returns the shifted value together with five condition flags: carry, overflow, sign, zero and parity. A caller raises `start` for one cycle. With it the caller presents the operand, a byte/word select, a direction, and one of three count sources: an implied count of one, an immediate count byte, or a count register byte. The unit answers with a one-cycle `done` pulse. Its timing follows a fixed cost model: the implied single shift is short, and every counted shift pays a base cost plus one cycle for each position moved.

Only the low five bits of any count byte are used, so a shift never moves more than 31 positions. A masked count of zero is legal. It returns the operand unchanged and keeps the previous flag values. The result and flag outputs are registers. They change only on the cycle that `done` is high and hold their value between operations. The unit ignores a `start` request while `busy` is high.

Top module: `shifter_unit`

## Requirements
- R1: The shift count is the low 5 bits of the selected count byte (`countSel` 1 = `immCount`, 2 or 3 = `clCount`), so counts 32 and above wrap modulo 32. `countSel` 0 means a count of exactly one.
- R2: A left shift moves bits toward the MSB and brings zeros in at bit 0. The arithmetic and logical left forms are the same operation.
- R3: A right shift (`dirRight` = 1) moves bits toward bit 0 and brings zeros in at the size MSB.
- R4: For a nonzero count, `cfOut` is the last bit shifted out of the sized operand. This bit is 0 once the count exceeds the operand width.
- R5: For a count of exactly one, `ofOut` is 1 when the sign bit of the result differs from the sign bit of the operand. For counts of two or more, `ofOut` is 0.
- R6: For a nonzero count, `sfOut` is the result's size MSB (bit 7 or bit 15) and `zfOut` is 1 when the sized result is zero. `pfOut` is 1 when bits 7..0 of the result hold an even number of ones.
- R7: With `isWord` = 0, only bits 7..0 are shifted and flagged, and `result[15:8]` returns `operand[15:8]` unchanged.
- R8: `done` goes high 2 rising edges after the edge that samples `start` for `countSel` 0, and 5 + n edges after it for a counted shift of masked count n. `busy` is high from the edge after `start` until the edge that raises `done`.
- R9: A masked count of zero returns the operand as the result after 5 edges and leaves all five flag outputs at their previous values.
- R10: `done` is a single-cycle pulse. A `start` raised while `busy` is high is ignored and does not disturb the operation in flight.
- R11: While `rst_n` is low, `result`, all flags, `done` and `busy` are 0. Outside `done` cycles, `result` and the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| operand | input | 16 | Value to shift |
| isWord | input | 1 | 1 = 16-bit shift, 0 = low byte only |
| dirRight | input | 1 | 1 = logical right, 0 = left |
| countSel | input | 2 | 0 = single, 1 = immediate, 2/3 = count register |
| immCount | input | 8 | Immediate count byte |
| clCount | input | 8 | Count register byte |
| result | output | 16 | Shifted value |
| cfOut | output | 1 | Carry: last bit shifted out |
| ofOut | output | 1 | Overflow: sign change on single shift |
| sfOut | output | 1 | Sign of result |
| zfOut | output | 1 | Result is zero |
| pfOut | output | 1 | Even parity of result low byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, a 5-bit count, and latencies of 2 and 5. With these values the full count range of 0 to 31 is reachable, and the longest operation takes 36 cycles. Byte shifts of 9 to 31 positions let the bench cover carry-out after the operand has been fully shifted away. A 5-bit count field also makes the count bytes 32 and 33 wrap to 0 and 1, so the zero-count hold and the wrapped single shift can both be driven from the immediate and register sources.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    SRC_ONE  = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_REG  = 2'd2,
    SRC_REG2 = 2'd3
  } cntSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
    logic holdFlags;
    logic ofValid;
  } shStrobe_t;

endpackage

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import shifter_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int SRC_W      = 8,
  parameter int SINGLE_LAT = 2,
  parameter int BASE_LAT   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       countSel,
  input  logic [SRC_W-1:0] immCount,
  input  logic [SRC_W-1:0] clCount,
  output shStrobe_t        strobe,
  output logic             busy
);

  localparam int LAT_W = $clog2(BASE_LAT + (1 << CNT_W) + 1);

  cntSrc_e          src;
  logic [CNT_W-1:0] maskedCnt;
  logic [LAT_W-1:0] latency;
  logic [LAT_W-1:0] remain;
  logic [CNT_W-1:0] stepsLeft;
  logic             busyR;
  logic             holdR;
  logic             ofValidR;
  logic             unusedHiBits;

  assign src          = cntSrc_e'(countSel);
  assign unusedHiBits = ^{immCount[SRC_W-1:CNT_W], clCount[SRC_W-1:CNT_W]};

  always_comb begin
    case (src)
      SRC_ONE: maskedCnt = CNT_W'(1);
      SRC_IMM: maskedCnt = immCount[CNT_W-1:0];
      default: maskedCnt = clCount[CNT_W-1:0];
    endcase
    if (src == SRC_ONE) latency = LAT_W'(SINGLE_LAT);
    else                latency = LAT_W'(BASE_LAT) + LAT_W'(maskedCnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyR     <= 1'b0;
      remain    <= '0;
      stepsLeft <= '0;
      holdR     <= 1'b0;
      ofValidR  <= 1'b0;
    end else if (!busyR) begin
      if (start) begin
        busyR     <= 1'b1;
        remain    <= latency;
        stepsLeft <= maskedCnt;
        holdR     <= (maskedCnt == '0);
        ofValidR  <= (maskedCnt == CNT_W'(1));
      end
    end else begin
      if (stepsLeft != '0) stepsLeft <= stepsLeft - 1'b1;
      if (remain == LAT_W'(1)) busyR <= 1'b0;
      remain <= remain - 1'b1;
    end
  end

  assign strobe.load      = !busyR && start;
  assign strobe.step      = busyR && (stepsLeft != '0);
  assign strobe.finish    = busyR && (remain == LAT_W'(1));
  assign strobe.holdFlags = holdR;
  assign strobe.ofValid   = ofValidR;
  assign busy             = busyR;

endmodule

// File: rtl/shifter_dp.sv
module shifter_dp
  import shifter_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shStrobe_t         strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic              isWord,
  input  logic              dirRight,
  output logic [DATA_W-1:0] result,
  output logic              cfOut,
  output logic              ofOut,
  output logic              sfOut,
  output logic              zfOut,
  output logic              pfOut,
  output logic              done
);

  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] work;
  logic [DATA_W-1:0] nextWork;
  logic [DATA_W-1:0] szMask;
  logic [DATA_W-1:0] ldMask;
  logic [HI_W-1:0]   upperR;
  logic              wordR;
  logic              rightR;
  logic              lastOut;
  logic              origMsb;
  logic              shiftedOut;
  logic              curMsb;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < BYTE_W) begin : g_low
      assign szMask[i] = 1'b1;
      assign ldMask[i] = 1'b1;
    end else begin : g_high
      assign szMask[i] = wordR;
      assign ldMask[i] = isWord;
    end
  end

  always_comb begin
    curMsb = wordR ? work[DATA_W-1] : work[BYTE_W-1];
    if (rightR) begin
      nextWork   = (work >> 1) & szMask;
      shiftedOut = work[0];
    end else begin
      nextWork   = (work << 1) & szMask;
      shiftedOut = curMsb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work    <= '0;
      upperR  <= '0;
      wordR   <= 1'b0;
      rightR  <= 1'b0;
      lastOut <= 1'b0;
      origMsb <= 1'b0;
    end else if (strobe.load) begin
      work    <= operand & ldMask;
      upperR  <= operand[DATA_W-1:BYTE_W];
      wordR   <= isWord;
      rightR  <= dirRight;
      lastOut <= 1'b0;
      origMsb <= isWord ? operand[DATA_W-1] : operand[BYTE_W-1];
    end else if (strobe.step) begin
      work    <= nextWork;
      lastOut <= shiftedOut;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      cfOut  <= 1'b0;
      ofOut  <= 1'b0;
      sfOut  <= 1'b0;
      zfOut  <= 1'b0;
      pfOut  <= 1'b0;
      done   <= 1'b0;
    end else if (strobe.finish) begin
      done   <= 1'b1;
      result <= wordR ? work : {upperR, work[BYTE_W-1:0]};
      if (!strobe.holdFlags) begin
        cfOut <= lastOut;
        ofOut <= strobe.ofValid ? (origMsb ^ curMsb) : 1'b0;
        sfOut <= curMsb;
        zfOut <= (work == '0);
        pfOut <= ~^work[BYTE_W-1:0];
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/shifter_unit.sv
module shifter_unit
  import shifter_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 5,
  parameter int SRC_W      = 8,
  parameter int SINGLE_LAT = 2,
  parameter int BASE_LAT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  input  logic              isWord,
  input  logic              dirRight,
  input  logic [1:0]        countSel,
  input  logic [SRC_W-1:0]  immCount,
  input  logic [SRC_W-1:0]  clCount,
  output logic [DATA_W-1:0] result,
  output logic              cfOut,
  output logic              ofOut,
  output logic              sfOut,
  output logic              zfOut,
  output logic              pfOut,
  output logic              done,
  output logic              busy
);

  shStrobe_t strobe;

  shifter_ctrl #(
    .CNT_W(CNT_W), .SRC_W(SRC_W), .SINGLE_LAT(SINGLE_LAT), .BASE_LAT(BASE_LAT)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .countSel(countSel),
    .immCount(immCount), .clCount(clCount), .strobe(strobe), .busy(busy)
  );

  shifter_dp #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .operand(operand),
    .isWord(isWord), .dirRight(dirRight), .result(result),
    .cfOut(cfOut), .ofOut(ofOut), .sfOut(sfOut), .zfOut(zfOut),
    .pfOut(pfOut), .done(done)
  );

endmodule

// File: rtl/shifter_unit_chk.sv
module shifter_unit_chk #(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 5,
  parameter int SRC_W      = 8,
  parameter int SINGLE_LAT = 2,
  parameter int BASE_LAT   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        countSel,
  input logic [SRC_W-1:0]  immCount,
  input logic [SRC_W-1:0]  clCount,
  input logic [DATA_W-1:0] result,
  input logic              ofOut,
  input logic              pfOut,
  input logic              done,
  input logic              busy
);

  localparam int LAT_W = $clog2(BASE_LAT + (1 << CNT_W) + 1) + 1;

  logic             tracking;
  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] expLat;
  logic [CNT_W-1:0] nLat;
  logic [CNT_W-1:0] reqCnt;
  logic             unusedChkBits;

  assign unusedChkBits = ^{immCount[SRC_W-1:CNT_W], clCount[SRC_W-1:CNT_W]};
  assign reqCnt = (countSel == 2'd0) ? CNT_W'(1) :
                  (countSel == 2'd1) ? immCount[CNT_W-1:0] : clCount[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tracking <= 1'b0;
      cnt      <= '0;
      expLat   <= '0;
      nLat     <= '0;
    end else if (!busy && start) begin
      tracking <= 1'b1;
      cnt      <= '0;
      nLat     <= reqCnt;
      expLat   <= (countSel == 2'd0) ? LAT_W'(SINGLE_LAT) : LAT_W'(BASE_LAT) + LAT_W'(reqCnt);
    end else if (tracking) begin
      if (done) tracking <= 1'b0;
      else      cnt <= cnt + 1'b1;
    end
  end

  // R8: completion arrives exactly at the cost-model latency
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && done) |-> (cnt == expLat));

  // R8: busy and done never overlap
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: done lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: an idle request is accepted
  assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R11: outputs hold between completions
  assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result)));

  // R5: multi-bit shifts report no overflow
  assert_of_multi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && done && (nLat > CNT_W'(1))) |-> !ofOut);

  // R6: parity tracks the low byte of a fresh result
  assert_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && done && (nLat != '0)) |-> (pfOut == ~^result[7:0]));

endmodule

bind shifter_unit shifter_unit_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .SRC_W(SRC_W),
  .SINGLE_LAT(SINGLE_LAT), .BASE_LAT(BASE_LAT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .countSel(countSel),
  .immCount(immCount), .clCount(clCount), .result(result),
  .ofOut(ofOut), .pfOut(pfOut), .done(done), .busy(busy)
);

// File: tb/shifter_unit_tb_top.sv
`timescale 1ns/1ps
module shifter_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] operand = '0;
  logic        isWord = 1'b0;
  logic        dirRight = 1'b0;
  logic [1:0]  countSel = '0;
  logic [7:0]  immCount = '0;
  logic [7:0]  clCount = '0;
  logic [15:0] result;
  logic        cfOut, ofOut, sfOut, zfOut, pfOut, done, busy;

  always #2 clk = ~clk;

  shifter_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .isWord(isWord), .dirRight(dirRight), .countSel(countSel),
    .immCount(immCount), .clCount(clCount), .result(result),
    .cfOut(cfOut), .ofOut(ofOut), .sfOut(sfOut), .zfOut(zfOut),
    .pfOut(pfOut), .done(done), .busy(busy)
  );

  int    compared = 0;
  int    mismatched = 0;
  bit    cmpOn = 0;
  string curReq = "R11";

  // behavioural reference state
  int   mRemain = 0;
  bit   mBusy = 0, mDone = 0;
  int   mRes = 0;
  bit   mCf = 0, mOf = 0, mSf = 0, mZf = 0, mPf = 0;
  int   pRes = 0, pLat = 0;
  bit   pCf, pOf, pSf, pZf, pPf, pHold;

  task automatic predict(input int op, input bit word, input bit right,
                         input int sel, input int imm, input int cl);
    int n, width, v, ones;
    bit c;
    n = (sel == 0) ? 1 : ((sel == 1) ? (imm % 32) : (cl % 32));
    width = word ? 16 : 8;
    v = word ? op : (op & 255);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (right) begin
        c = v[0];
        v = v >> 1;
      end else begin
        c = v[width-1];
        v = (v << 1) & ((1 << width) - 1);
      end
    end
    ones = 0;
    for (int b = 0; b < 8; b++) ones += v[b];
    pHold = (n == 0);
    pCf = c;
    pSf = v[width-1];
    pOf = (n == 1) ? (op[width-1] != v[width-1]) : 1'b0;
    pZf = (v == 0);
    pPf = (ones % 2 == 0);
    pRes = word ? v : ((op & 16'hFF00) | v);
    pLat = (sel == 0) ? 2 : 5 + n;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; mDone = 0; mRes = 0; mRemain = 0;
      mCf = 0; mOf = 0; mSf = 0; mZf = 0; mPf = 0;
    end else if (mBusy) begin
      mRemain--;
      if (mRemain == 0) begin
        mBusy = 0; mDone = 1; mRes = pRes;
        if (!pHold) begin
          mCf = pCf; mOf = pOf; mSf = pSf; mZf = pZf; mPf = pPf;
        end
      end else mDone = 0;
    end else begin
      mDone = 0;
      if (start) begin
        predict(operand, isWord, dirRight, countSel, immCount, clCount);
        mBusy = 1;
        mRemain = pLat;
      end
    end
  end

  task automatic cmp(input string name, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", curReq, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      cmp("result", result, mRes);
      cmp("cf", cfOut, mCf);
      cmp("of", ofOut, mOf);
      cmp("sf", sfOut, mSf);
      cmp("zf", zfOut, mZf);
      cmp("pf", pfOut, mPf);
      cmp("done", done, mDone);
      cmp("busy", busy, mBusy);
    end
  end

  task automatic launch(input logic [15:0] op, input bit word, input bit right,
                        input logic [1:0] sel, input logic [7:0] imm, input logic [7:0] cl);
    @(negedge clk);
    operand = op; isWord = word; dirRight = right;
    countSel = sel; immCount = imm; clCount = cl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!mDone) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runOp(input string tag, input logic [15:0] op, input bit word,
                       input bit right, input logic [1:0] sel,
                       input logic [7:0] imm, input logic [7:0] cl);
    curReq = tag;
    launch(op, word, right, sel, imm, cl);
    waitDone();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R11: reset state
    curReq = "R11";
    @(negedge clk);
    cmpOn = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    runOp("R2",  16'h8001, 1, 0, 2'd0, 8'd0,   8'd0);   // single left, sign flips
    runOp("R3",  16'h8001, 1, 1, 2'd0, 8'd0,   8'd0);   // single right
    runOp("R4",  16'h1234, 1, 0, 2'd1, 8'd4,   8'd0);   // carry from bit 12
    runOp("R3",  16'h00F5, 1, 1, 2'd1, 8'd3,   8'd0);
    runOp("R1",  16'h4000, 1, 0, 2'd1, 8'd33,  8'd0);   // wraps to 1
    runOp("R1",  16'h0F0F, 1, 1, 2'd2, 8'd0,   8'hE2);  // wraps to 2
    runOp("R5",  16'h4000, 1, 0, 2'd1, 8'd1,   8'd0);   // overflow set
    runOp("R5",  16'h4000, 1, 0, 2'd1, 8'd2,   8'd0);   // multi-bit, of 0
    runOp("R6",  16'h0001, 1, 1, 2'd0, 8'd0,   8'd0);   // zero result
    runOp("R7",  16'hAB81, 0, 0, 2'd3, 8'd0,   8'd3);   // byte left
    runOp("R7",  16'hCDF0, 0, 1, 2'd2, 8'd0,   8'd9);   // byte beyond width
    runOp("R4",  16'h12FF, 0, 0, 2'd1, 8'd31,  8'd0);
    runOp("R8",  16'hFFFF, 1, 0, 2'd1, 8'd31,  8'd0);   // longest
    runOp("R9",  16'h5A5A, 1, 1, 2'd1, 8'd32,  8'd0);   // zero count, flags hold
    runOp("R9",  16'h00C3, 0, 0, 2'd2, 8'd0,   8'd64);

    // R10: request during busy is dropped
    curReq = "R10";
    launch(16'h0081, 1, 0, 2'd1, 8'd6, 8'd0);
    @(negedge clk);
    operand = 16'hFFFF; dirRight = 1'b1; countSel = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();

    // mixed patterns
    for (int k = 0; k < 40; k++) begin
      runOp("R6", 16'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
            8'($urandom), 8'($urandom));
    end
    // back-to-back request on the cycle done is high
    curReq = "R8";
    launch(16'h8000, 1, 1, 2'd0, 8'd0, 8'd0);
    while (!mDone) @(negedge clk);
    start = 1'b1; operand = 16'h0003; dirRight = 1'b0; countSel = 2'd1; immCount = 8'd1;
    @(negedge clk);
    start = 1'b0;
    waitDone();

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule